// File: doc/BRIEF.md
# SPI Controller Interrupt Aggregator

This block collects seven event pulses from an SPI controller into one interrupt line. A pending register catches the rising edge of each event, a mask register selects which pending sources may raise the line, and a single global enable gates the combined result. Software learns which sources fired by reading the pending register, and acknowledges them by writing the same value back.

The block also carries a keyed soft-reset register. Writing the key value asserts a reset output toward the attached controller for a fixed number of cycles and returns every register in this block to zero. Access is through a single-cycle register port: a write strobe with address and data, and a read data bus that follows the address combinationally. The event that drives a controller's "transfer complete" handshake is the transmit-empty source.

Top module: `spi_irq_ctrl`

## Requirements
- R1: The register map uses byte addresses 0x1C (global enable, bit 31 only), 0x20 (pending, bits [6:0]), 0x28 (mask, bits [6:0]) and 0x40 (soft reset, reads zero). All other addresses and all unused bits read zero, and writes to unused bits are dropped.
- R2: Source input bit i maps to pending and mask bit i. The assignments are: 0 mode fault, 1 slave-select fault, 2 transmit empty, 3 transmit underrun, 4 receive full, 5 receive overrun, 6 transmit half empty.
- R3: A pending bit is set at the clock edge where its source input is 1 and was 0 in the previous cycle. This happens whatever the mask holds. A source held high does not set its bit again after the bit is cleared.
- R4: Writing to the pending register clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R5: When a rising source edge and a write that clears the same pending bit arrive at the same edge, the bit is left set.
- R6: With the global enable set, `irq` is 1 exactly when some bit is both pending and unmasked. It reflects the register state after each clock edge.
- R7: While the global enable bit is 0, `irq` is 0 whatever is pending and unmasked.
- R8: Writing exactly 0x0000000A to address 0x40 raises `core_rst` for RST_CYCLES cycles, starting at that write's edge, and clears the pending, mask and global enable registers. Register writes and source edges made while `core_rst` is high are ignored.
- R9: Writing any other value to address 0x40 leaves `core_rst` low and every register unchanged.
- R10: After the hardware reset `rst_n`, all registers read zero and `irq` and `core_rst` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | ADDR_W | Byte address for reads and writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| src_evt | input | NUM_SRC | Event inputs from the controller |
| irq | output | 1 | Combined interrupt line |
| core_rst | output | 1 | Soft reset to the attached controller |

## Verification
The bench builds the block with NUM_SRC at its default of 7 and RST_CYCLES set to 3. A pulse length of 3 separates a correct pulse width from errors of one cycle in either direction. With seven sources, every mask value can be crossed with every event pattern, 16384 pairs, within the cycle budget. This exercises the interrupt equation completely rather than by sampling. Directed sequences then cover per-bit mapping, partial clears, the clear-versus-event race, a held source level, and both a correct and a wrong reset key.

// File: rtl/spi_irq_ctrl.sv
module spi_irq_ctrl #(
  parameter int NUM_SRC    = 7,
  parameter int RST_CYCLES = 2,
  parameter int ADDR_W     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [NUM_SRC-1:0] src_evt,
  output logic              irq,
  output logic              core_rst
);

  localparam logic [ADDR_W-1:0] A_GIE = ADDR_W'('h1C);
  localparam logic [ADDR_W-1:0] A_ISR = ADDR_W'('h20);
  localparam logic [ADDR_W-1:0] A_IER = ADDR_W'('h28);
  localparam logic [ADDR_W-1:0] A_RST = ADDR_W'('h40);
  localparam logic [31:0]       RST_KEY = 32'h0000_000A;
  localparam int                CNT_W = $clog2(RST_CYCLES + 1);
  localparam int                PAD_W = 32 - NUM_SRC;

  logic [NUM_SRC-1:0] evt_q, pend, mask, rise, clr;
  logic               gie, busy;
  logic [CNT_W-1:0]   rst_cnt;
  logic               wr_gie, wr_isr, wr_ier, key_ok;

  assign busy   = (rst_cnt != '0);
  assign wr_gie = reg_we && !busy && (reg_addr == A_GIE);
  assign wr_isr = reg_we && !busy && (reg_addr == A_ISR);
  assign wr_ier = reg_we && !busy && (reg_addr == A_IER);
  assign key_ok = reg_we && !busy && (reg_addr == A_RST) && (reg_wdata == RST_KEY);
  assign rise   = src_evt & ~evt_q;
  assign clr    = wr_isr ? reg_wdata[NUM_SRC-1:0] : '0;

  assign irq      = gie & (|(pend & mask));
  assign core_rst = busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_q   <= '0;
      pend    <= '0;
      mask    <= '0;
      gie     <= 1'b0;
      rst_cnt <= '0;
    end else begin
      evt_q <= src_evt;
      if (busy) begin
        rst_cnt <= rst_cnt - 1'b1;
        pend    <= '0;
        mask    <= '0;
        gie     <= 1'b0;
      end else if (key_ok) begin
        rst_cnt <= CNT_W'(RST_CYCLES);
        pend    <= '0;
        mask    <= '0;
        gie     <= 1'b0;
      end else begin
        pend <= (pend & ~clr) | rise;
        if (wr_ier) mask <= reg_wdata[NUM_SRC-1:0];
        if (wr_gie) gie  <= reg_wdata[31];
      end
    end
  end

  always_comb begin
    case (reg_addr)
      A_GIE:   reg_rdata = {gie, 31'b0};
      A_ISR:   reg_rdata = {{PAD_W{1'b0}}, pend};
      A_IER:   reg_rdata = {{PAD_W{1'b0}}, mask};
      default: reg_rdata = '0;
    endcase
  end

  AST_EDGE_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !key_ok && (rise != '0)) |=> ((pend & $past(rise)) == $past(rise))); // R3 R5

  AST_PEND_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !key_ok && !wr_isr && (rise == '0)) |=> $stable(pend)); // R4

  AST_KEY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    key_ok |=> (core_rst && !irq && (pend == '0) && (mask == '0) && !gie)); // R8

  AST_BAD_KEY_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && reg_we && (reg_addr == A_RST) && (reg_wdata != RST_KEY)) |=> !core_rst); // R9

  AST_GIE_GATES: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !key_ok && !wr_gie && !gie) |=> !irq); // R7

endmodule

// File: tb/spi_irq_ctrl_tb.sv
module spi_irq_ctrl_tb;
  localparam int NS = 7;
  localparam int RC = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [NS-1:0] src_evt = '0;
  logic        irq, core_rst;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  spi_irq_ctrl #(.NUM_SRC(NS), .RST_CYCLES(RC), .ADDR_W(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .src_evt(src_evt),
    .irq(irq), .core_rst(core_rst));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    reg_addr = a;
    #1;
    v = reg_rdata;
  endtask

  task automatic pulse(input logic [NS-1:0] p);
    @(negedge clk);
    src_evt = p;
    @(negedge clk);
    src_evt = '0;
  endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [31:0] v;
    int hi;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 reset state
    rd(8'h1C, v); check("R10 gie", v, 0);
    rd(8'h20, v); check("R10 pend", v, 0);
    rd(8'h28, v); check("R10 mask", v, 0);
    check("R10 irq", {31'b0, irq}, 0);
    check("R10 core_rst", {31'b0, core_rst}, 0);

    // R1 map and unused bits
    wr(8'h28, 32'hFFFF_FFFF); rd(8'h28, v); check("R1 mask bits", v, 32'h7F);
    wr(8'h1C, 32'hFFFF_FFFF); rd(8'h1C, v); check("R1 gie bit31", v, 32'h8000_0000);
    rd(8'h40, v); check("R1 reset reads zero", v, 0);
    rd(8'h24, v); check("R1 unmapped zero", v, 0);
    wr(8'h28, 0); wr(8'h1C, 0);

    // R2 / R3 bit mapping, latched while masked
    for (int i = 0; i < NS; i++) begin
      pulse(NS'(1 << i));
      rd(8'h20, v); check("R2 bit position", v, 32'(1 << i));
      check("R3 masked no irq", {31'b0, irq}, 0);
      wr(8'h20, 32'h7F);
    end

    // R6 sweep of all masks against all event patterns
    wr(8'h1C, 32'h8000_0000);
    for (int m = 0; m < 128; m++) begin
      wr(8'h28, 32'(m));
      for (int p = 0; p < 128; p++) begin
        pulse(NS'(p));
        rd(8'h20, v); check("R3 pend pattern", v, 32'(p));
        check("R6 irq", {31'b0, irq}, {31'b0, ((p & m) != 0)});
        wr(8'h20, 32'h7F);
        rd(8'h20, v); check("R4 clear all", v, 0);
      end
    end

    // R4 partial clear
    pulse(7'h7F);
    wr(8'h20, 32'h15); rd(8'h20, v); check("R4 partial clear", v, 32'h6A);
    wr(8'h20, 32'h7F);

    // R3 held level does not reassert
    @(negedge clk); src_evt = 7'h01;
    @(negedge clk);
    wr(8'h20, 32'h01);
    repeat (3) @(negedge clk);
    rd(8'h20, v); check("R3 held level", v, 0);
    src_evt = '0;
    @(negedge clk);

    // R5 event beats clear
    pulse(7'h04);
    @(negedge clk);
    src_evt = 7'h04; reg_we = 1'b1; reg_addr = 8'h20; reg_wdata = 32'h04;
    @(negedge clk);
    reg_we = 1'b0; src_evt = '0;
    rd(8'h20, v); check("R5 event wins", v, 32'h04);

    // R7 global enable gating
    wr(8'h28, 32'h7F);
    wr(8'h1C, 0); rd(8'h20, v);
    check("R7 gie off", {31'b0, irq}, 0);
    wr(8'h1C, 32'h8000_0000); rd(8'h20, v);
    check("R7 gie on", {31'b0, irq}, 1);

    // R9 wrong key
    wr(8'h40, 32'h0B);
    check("R9 no reset", {31'b0, core_rst}, 0);
    rd(8'h28, v); check("R9 mask kept", v, 32'h7F);
    wr(8'h40, 32'h1_000A);
    check("R9 upper bits", {31'b0, core_rst}, 0);
    rd(8'h20, v); check("R9 pend kept", v, 32'h04);

    // R8 keyed reset
    wr(8'h40, 32'h0A);
    hi = 0;
    for (int k = 0; k < RC + 2; k++) begin
      if (core_rst) hi++;
      if (k == 0) begin
        reg_we = 1'b1; reg_addr = 8'h28; reg_wdata = 32'h7F;
      end
      @(negedge clk);
      reg_we = 1'b0;
    end
    check("R8 pulse length", 32'(hi), 32'(RC));
    rd(8'h20, v); check("R8 pend zero", v, 0);
    rd(8'h28, v); check("R8 mask zero and write ignored", v, 0);
    rd(8'h1C, v); check("R8 gie zero", v, 0);
    check("R8 irq low", {31'b0, irq}, 0);

    summary();
  end
endmodule